// File: doc/BRIEF.md
# SPI Register-Access Slave

This block lets an SPI master read and write a small bank of byte-wide registers. The serial pins (clock, data in, active-low select) are brought into the system clock domain through flip-flop synchronisers. Their edges are then detected and handled by a byte shift engine running on the fast system clock. MISO comes with a separate output enable, so that a pad or an on-chip bus driver can release the line whenever the slave is not selected.

Each transaction opens with a command byte. Its top bit chooses read or write, and its remaining seven bits give a register address, of which the low bits index the bank. While the command is still arriving, the slave shifts a status byte back to the master. The following bytes either write successive registers or return their contents, and the address steps up by one after each data byte. If the master drops select in the middle of a byte, that byte is discarded, and a sticky flag records the event for the master to see in the next status byte. The whole bank is also presented in parallel so that surrounding logic can use the values as control settings.

Top module: `spi_reg_slave`

## Requirements
- R1: While the synchronised select is high, miso_oe_o is 0 and miso_o is 0. While select is low, miso_oe_o is 1.
- R2: After reset every register reads zero on cfg_o, and miso_oe_o is 0.
- R3: A command with bit 7 = 0 is a write. The byte that follows it is stored in the register indexed by the command's low 4 bits. Register i appears on cfg_o[8i+7:8i].
- R4: A command with bit 7 = 1 is a read. Each byte that follows it returns the addressed register on MISO, MSB first. MOSI is sampled on the SCK rising edge and MISO changes after the falling edge.
- R5: While the command byte is being received, the slave shifts out a status byte. Bit 0 of that byte is the partial-byte flag and bits 7:1 are 0.
- R6: After each data byte the address advances by one within the transaction, wrapping from register 15 to register 0.
- R7: Raising select in the middle of a byte discards that byte without any write, and the next transaction starts its bit count afresh.
- R8: The partial-byte flag is set when a transaction ends with an incomplete byte. It is cleared once a command byte has been fully received, so the flag is reported once. A transaction that ends on a byte boundary leaves the flag at 0.
- R9: SCK and MOSI activity while select is high changes no register.
- R10: Command address bits 6:4 are ignored when indexing the 16-entry bank.
- R11: Bytes received on MOSI during a read transaction modify no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the master (idle low) |
| mosi_i | input | 1 | Serial data from the master |
| ss_n_i | input | 1 | Active-low slave select |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for MISO; 0 means the line is released |
| cfg_o | output | NREG*8 | Parallel view of every register, register i in bits 8i+7:8i |

## Verification
Single-byte writes and reads at one address separate a correct command decode from swapped read/write polarity or wrong bit order. A burst that starts at register 14 catches a missing auto-increment or a missing wrap to register 0. An all-ones MOSI stream during a read shows whether read transactions leak writes. A transaction cut after four data bits, followed by two complete transactions, shows whether the partial byte is written, whether the bit counter is left dirty, and whether the sticky flag is both set and then cleared. Toggling SCK with select high, and writing through an address with high bits set, test that deselected traffic is ignored and that addresses alias correctly.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned BIT_CW = $clog2(BYTE_W);

   typedef logic [BYTE_W-1:0] byte_t;

   typedef enum logic {
      ACC_WRITE = 1'b0,
      ACC_READ  = 1'b1
   } acc_e;

   typedef struct packed {
      acc_e                  acc;
      logic [BYTE_W-2:0]     addr;
   } cmd_t;

   function automatic byte_t make_status(input logic partial_flag);
      byte_t s;
      s    = '0;
      s[0] = partial_flag;
      return s;
   endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
   parameter int unsigned WIDTH   = 3,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
         else        chain <= {chain[STAGES-2:0], d[g]};
      end
      assign q[g] = chain[STAGES-1];
   end
endmodule

// File: rtl/spi_shift.sv
module spi_shift
   import spi_reg_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  sel,
   input  logic  sel_start,
   input  logic  sck_rise,
   input  logic  sck_fall,
   input  logic  mosi,
   input  byte_t status_i,
   input  byte_t load_i,
   output logic  miso_bit,
   output logic  byte_done,
   output byte_t rx_byte,
   output logic  partial
);
   localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);

   logic [BIT_CW-1:0] bit_cnt;
   logic [BYTE_W-2:0] rx_sh;
   byte_t             tx_sh;
   logic              pend_load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         rx_sh     <= '0;
         tx_sh     <= '0;
         pend_load <= 1'b0;
      end else if (!sel) begin
         bit_cnt   <= '0;
         pend_load <= 1'b0;
      end else if (sel_start) begin
         bit_cnt   <= '0;
         pend_load <= 1'b0;
         tx_sh     <= status_i;
      end else begin
         if (sck_rise) begin
            rx_sh   <= {rx_sh[BYTE_W-3:0], mosi};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) pend_load <= 1'b1;
         end
         if (sck_fall) begin
            if (pend_load) begin
               tx_sh     <= load_i;
               pend_load <= 1'b0;
            end else begin
               tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
         end
      end
   end

   assign miso_bit  = tx_sh[BYTE_W-1];
   assign byte_done = sel && !sel_start && sck_rise && (bit_cnt == LAST_BIT);
   assign rx_byte   = {rx_sh, mosi};
   assign partial   = (bit_cnt != '0);
endmodule

// File: rtl/spi_regbank.sv
module spi_regbank
   import spi_reg_pkg::*;
#(
   parameter int unsigned NREG = 16,
   localparam int unsigned IDXW = $clog2(NREG)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [IDXW-1:0]        widx,
   input  byte_t                  wdata,
   input  logic [IDXW-1:0]        ridx,
   output byte_t                  rdata,
   output logic [NREG*BYTE_W-1:0] flat_o
);
   byte_t regs [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          regs[g] <= '0;
         else if (we && widx == IDXW'(g))     regs[g] <= wdata;
      end
      assign flat_o[g*BYTE_W +: BYTE_W] = regs[g];
   end

   assign rdata = regs[ridx];
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
   import spi_reg_pkg::*;
#(
   parameter int unsigned NREG        = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   sck_i,
   input  logic                   mosi_i,
   input  logic                   ss_n_i,
   output logic                   miso_o,
   output logic                   miso_oe_o,
   output logic [NREG*BYTE_W-1:0] cfg_o
);
   localparam int unsigned IDXW = $clog2(NREG);
   localparam int unsigned AW   = BYTE_W - 1;

   if ((NREG & (NREG - 1)) != 0 || NREG < 2) begin : g_bad_nreg
      $error("spi_reg_slave: NREG must be a power of two, at least 2");
   end
   if (NREG > (1 << AW)) begin : g_bad_span
      $error("spi_reg_slave: NREG exceeds the command address span");
   end

   // synchronised pins: {ss_n, mosi, sck}; select idles high
   logic [2:0] pins_s;
   spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk (clk),
      .rst_n (rst_n),
      .d   ({ss_n_i, mosi_i, sck_i}),
      .q   (pins_s)
   );

   logic sck_s, mosi_s, ss_n_s;
   assign {ss_n_s, mosi_s, sck_s} = pins_s;

   logic sck_q, ss_n_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q  <= 1'b0;
         ss_n_q <= 1'b1;
      end else begin
         sck_q  <= sck_s;
         ss_n_q <= ss_n_s;
      end
   end

   logic sel, sel_start, sel_end, sck_rise, sck_fall;
   assign sel       = !ss_n_s;
   assign sel_start = sel && ss_n_q;
   assign sel_end   = ss_n_s && !ss_n_q;
   assign sck_rise  = sck_s && !sck_q;
   assign sck_fall  = !sck_s && sck_q;

   // transaction state
   logic            in_cmd;
   acc_e            acc;
   logic [AW-1:0]   addr;
   logic            sticky;

   logic  byte_done, partial, miso_bit, we;
   byte_t rx_byte, rdata, load_byte, status_byte;
   cmd_t  cmd;

   assign cmd         = cmd_t'(rx_byte);
   assign status_byte = make_status(sticky);
   assign load_byte   = (acc == ACC_READ) ? rdata : '0;
   assign we          = byte_done && !in_cmd && (acc == ACC_WRITE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_cmd <= 1'b1;
         acc    <= ACC_WRITE;
         addr   <= '0;
      end else if (!sel) begin
         in_cmd <= 1'b1;
      end else if (byte_done) begin
         if (in_cmd) begin
            in_cmd <= 1'b0;
            acc    <= cmd.acc;
            addr   <= cmd.addr;
         end else begin
            addr <= addr + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      sticky <= 1'b0;
      else if (sel_end && partial)     sticky <= 1'b1;
      else if (byte_done && in_cmd)    sticky <= 1'b0;
   end

   spi_shift u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (sel),
      .sel_start (sel_start),
      .sck_rise  (sck_rise),
      .sck_fall  (sck_fall),
      .mosi      (mosi_s),
      .status_i  (status_byte),
      .load_i    (load_byte),
      .miso_bit  (miso_bit),
      .byte_done (byte_done),
      .rx_byte   (rx_byte),
      .partial   (partial)
   );

   spi_regbank #(.NREG(NREG)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (we),
      .widx   (addr[IDXW-1:0]),
      .wdata  (rx_byte),
      .ridx   (addr[IDXW-1:0]),
      .rdata  (rdata),
      .flat_o (cfg_o)
   );

   assign miso_oe_o = sel;
   assign miso_o    = sel & miso_bit;
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk #(
   parameter int unsigned NREG = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              miso_o,
   input logic              miso_oe_o,
   input logic [NREG*8-1:0] cfg_o
);
   logic [NREG*8-1:0] cfg_prev;
   logic [NREG-1:0]   chg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_prev <= '0;
      else        cfg_prev <= cfg_o;
   end

   for (genvar g = 0; g < NREG; g++) begin : g_chg
      assign chg[g] = (cfg_o[g*8 +: 8] != cfg_prev[g*8 +: 8]);
   end

   p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !miso_oe_o |-> !miso_o)
      else $error("R1: MISO driven while released");

   p_reset_clear_r2: assert property (@(posedge clk)
      $rose(rst_n) |-> (cfg_o == '0 && !miso_oe_o))
      else $error("R2: state not cleared by reset");

   p_one_reg_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chg))
      else $error("R3: more than one register changed in a cycle");

   p_no_write_deselected_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !miso_oe_o |=> $stable(cfg_o))
      else $error("R9: register changed while deselected");
endmodule

bind spi_reg_slave spi_reg_slave_chk #(.NREG(NREG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .miso_o    (miso_o),
   .miso_oe_o (miso_oe_o),
   .cfg_o     (cfg_o)
);

// File: tb/sim_spi_reg_slave.sv
module sim_spi_reg_slave;
   localparam int NREG = 16;
   localparam int HP   = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
   logic miso, miso_oe;
   logic [NREG*8-1:0] cfg;

   int n_vec = 0;
   int n_bad = 0;
   logic [7:0] exp_reg [NREG];

   always #5 clk = ~clk;

   spi_reg_slave #(.NREG(NREG)) u0 (
      .clk (clk), .rst_n (rst_n), .sck_i (sck), .mosi_i (mosi),
      .ss_n_i (ss_n), .miso_o (miso), .miso_oe_o (miso_oe), .cfg_o (cfg)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
      end
   endtask

   task automatic chk_bank(input string req);
      for (int i = 0; i < NREG; i++)
         chk(req, $sformatf("reg %0d", i), {24'd0, cfg[i*8 +: 8]}, {24'd0, exp_reg[i]});
   endtask

   task automatic ss_lo();
      ss_n = 1'b0;
      tick(HP);
   endtask

   task automatic ss_hi();
      tick(HP);
      ss_n = 1'b1;
      tick(2*HP);
   endtask

   task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
      rx = '0;
      for (int i = 7; i > 7 - n; i--) begin
         mosi = tx[i];
         tick(HP);
         rx[i] = miso;
         sck = 1'b1;
         tick(HP);
         sck = 1'b0;
      end
   endtask

   task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
      spi_bits(tx, 8, rx);
   endtask

   // R1, R2
   task automatic t_reset();
      chk("R2", "oe after reset", {31'd0, miso_oe}, 32'd0);
      chk("R1", "miso released", {31'd0, miso}, 32'd0);
      chk_bank("R2");
   endtask

   // R3, R5, R1
   task automatic t_write_single();
      logic [7:0] st, d;
      ss_lo();
      chk("R1", "oe while selected", {31'd0, miso_oe}, 32'd1);
      spi_byte(8'h03, st);
      chk("R5", "status clean", {24'd0, st}, 32'h00);
      spi_byte(8'hA5, d);
      ss_hi();
      exp_reg[3] = 8'hA5;
      chk("R1", "oe after release", {31'd0, miso_oe}, 32'd0);
      chk_bank("R3");
   endtask

   // R4
   task automatic t_read_single();
      logic [7:0] st, d;
      ss_lo();
      spi_byte(8'h83, st);
      spi_byte(8'h00, d);
      ss_hi();
      chk("R4", "read reg 3", {24'd0, d}, {24'd0, exp_reg[3]});
   endtask

   // R6, R11
   task automatic t_burst();
      logic [7:0] st, d;
      logic [7:0] v [3] = '{8'h11, 8'h22, 8'h3C};
      ss_lo();
      spi_byte(8'h0E, st);
      for (int k = 0; k < 3; k++) spi_byte(v[k], d);
      ss_hi();
      exp_reg[14] = 8'h11; exp_reg[15] = 8'h22; exp_reg[0] = 8'h3C;
      chk_bank("R6");
      ss_lo();
      spi_byte(8'h8E, st);
      for (int k = 0; k < 3; k++) begin
         spi_byte(8'hFF, d);
         chk("R6", $sformatf("burst read %0d", k), {24'd0, d}, {24'd0, v[k]});
      end
      ss_hi();
      chk_bank("R11");
   endtask

   // R10
   task automatic t_alias();
      logic [7:0] st, d;
      ss_lo();
      spi_byte(8'h75, st);
      spi_byte(8'h5C, d);
      ss_hi();
      exp_reg[5] = 8'h5C;
      chk_bank("R10");
   endtask

   // R7, R8
   task automatic t_abort();
      logic [7:0] st, d;
      ss_lo();
      spi_byte(8'h02, st);
      spi_bits(8'hF0, 4, d);
      ss_hi();
      chk_bank("R7");
      ss_lo();
      spi_byte(8'h83, st);
      chk("R8", "sticky reported", {24'd0, st}, 32'h01);
      spi_byte(8'h00, d);
      chk("R7", "fresh count after abort", {24'd0, d}, {24'd0, exp_reg[3]});
      ss_hi();
      ss_lo();
      spi_byte(8'h85, st);
      chk("R8", "sticky cleared", {24'd0, st}, 32'h00);
      spi_byte(8'h00, d);
      ss_hi();
      chk("R4", "read reg 5", {24'd0, d}, {24'd0, exp_reg[5]});
   endtask

   // R9
   task automatic t_deselected();
      logic [7:0] d;
      spi_byte(8'h07, d);
      spi_byte(8'hEE, d);
      tick(2*HP);
      chk("R9", "oe stays low", {31'd0, miso_oe}, 32'd0);
      chk_bank("R9");
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < NREG; i++) exp_reg[i] = 8'h00;
      tick(4);
      t_reset();
      rst_n = 1'b1;
      tick(4);
      t_write_single();
      t_read_single();
      t_burst();
      t_alias();
      t_abort();
      t_deselected();
      summary();
      $finish;
   end
endmodule